// File: doc/BRIEF.md
# Timeplate Waveform Expander and Strobe Comparator

The block replays a stream of tester vectors as an oversampled per-pin waveform. Every accepted vector occupies a fixed number of consecutive sample-clock cycles called slots. For each pin and each slot, a small format table holds a 3-bit code. The code decides what the pin does in that slot: drive a constant low, drive the vector's data bit, repeat the pin's previous state, float, ignore, or compare. The waveform shape therefore comes from the table and not from a single fixed edge.

Generation pins (device inputs) leave the block as a level plus an output-enable pair. Acquisition pins (device outputs) are sampled every slot, but a sample is judged only in the slots whose code asks for a compare, against the vector's expected L, H or X. The first mismatch sets a sticky fail flag and captures the index of the offending vector.

Vectors arrive over a valid/ready stream. `vec_ready` is high only while no vector is playing or during the final slot of the playing vector, so vectors sent back to back produce a gapless waveform. If the source stalls at a boundary, the block goes idle. While idle, the pins keep their last state, nothing is compared, and the format table may be rewritten.

Top module: `vec_expander`

## Requirements
- R1: Each accepted vector plays for exactly SLOTS consecutive cycles. Slot s of a vector accepted at clock edge t is presented in the cycle that follows edge t+s. Vectors are numbered from 0 in acceptance order since reset.
- R2: `vec_ready` is 1 when no vector is playing or when the playing vector is in its last slot, and 0 otherwise. A transfer takes place on an edge where `vec_valid` and `vec_ready` are both 1.
- R3: Code 0 on a generation pin drives low: `drv_lvl`=0 and `drv_oe`=1.
- R4: Code 1 on a generation pin drives the vector's bit: `drv_lvl` equals the pin's bit of `vec_drv` and `drv_oe`=1.
- R5: Code 2 on a generation pin repeats the pin's level and enable from the previous cycle. This includes the last slot of the previous vector and idle cycles.
- R6: Any code from 3 to 7 on a generation pin floats it: `drv_oe`=0 and `drv_lvl`=0.
- R7: On an acquisition pin, only code 5 strobes. In a strobe slot, expectation 2'b01 (L) fails on a sampled 1 and expectation 2'b10 (H) fails on a sampled 0. Expectations 2'b00 and 2'b11 (X) never fail, and all other codes mask the pin.
- R8: `fail` rises in the cycle after the first failing slot and stays high until reset. `fail_vec` holds the index of the first failing vector.
- R9: While no vector is playing, the generation outputs keep their last state and no compare occurs.
- R10: Table writes take effect only while no vector is playing and are ignored otherwise. The table is addressed by pin (generation pins 0..N_DRV-1, then acquisition pins N_DRV..N_DRV+N_CMP-1) and by slot.
- R11: After reset, `vec_ready`=1, every generation pin floats with level 0, `fail`=0, `fail_vec`=0, and all table entries hold code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_pin | input | PIN_W | Pin address of the table write |
| tbl_slot | input | SLOT_W | Slot address of the table write |
| tbl_code | input | 3 | Format code written |
| vec_valid | input | 1 | Vector available |
| vec_ready | output | 1 | Block takes a vector on this edge |
| vec_drv | input | N_DRV | Drive data, one bit per generation pin |
| vec_exp | input | 2*N_CMP | Expected value, two bits per acquisition pin |
| drv_lvl | output | N_DRV | Generation pin levels |
| drv_oe | output | N_DRV | Generation pin enables (0 = high impedance) |
| cmp_in | input | N_CMP | Sampled acquisition pins |
| fail | output | 1 | Sticky mismatch flag |
| fail_vec | output | IDX_W | Index of the first failing vector |

## Verification
The bench builds the block with four generation pins, four acquisition pins and twenty slots per vector. With this size it can load a table in which one pin repeats its old state in slot 0 and follows the new data afterwards, and in which strobes fall in slots 11 and 12 as well as at both slot boundaries 0 and 19. On every slot that is not strobed, the acquisition pins carry the opposite of the expected value, so a strobe that leaks outside its slots would show up as a failure. Back-to-back vectors, a stalled source, a write attempted during playback and a second mismatch after the first are all reachable at this size.

// File: rtl/vwx_pkg.sv
package vwx_pkg;
  typedef enum logic [2:0] {
    TC_FORCE0 = 3'd0,
    TC_APPLY  = 3'd1,
    TC_HOLD   = 3'd2,
    TC_HIZ    = 3'd3,
    TC_MASK   = 3'd4,
    TC_EXPECT = 3'd5
  } tcode_e;

  localparam logic [1:0] EXP_LOW  = 2'b01;
  localparam logic [1:0] EXP_HIGH = 2'b10;
endpackage

// File: rtl/vwx_sequencer.sv
module vwx_sequencer #(
  parameter int SLOTS  = 20,
  parameter int IDX_W  = 16,
  parameter int N_DRV  = 4,
  parameter int N_CMP  = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_valid,
  output logic               vec_ready,
  input  logic [N_DRV-1:0]   vec_drv,
  input  logic [2*N_CMP-1:0] vec_exp,
  output logic               active_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_DRV-1:0]   drv_o,
  output logic [2*N_CMP-1:0] exp_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic               active_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [IDX_W-1:0]   cur_q, next_q;
  logic [N_DRV-1:0]   drv_q;
  logic [2*N_CMP-1:0] exp_q;
  logic               at_last, take;

  assign at_last   = active_q && (slot_q == LAST);
  assign vec_ready = !active_q || at_last;
  assign take      = vec_valid && vec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      cur_q    <= '0;
      next_q   <= '0;
      drv_q    <= '0;
      exp_q    <= '0;
    end else if (take) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      cur_q    <= next_q;
      next_q   <= next_q + IDX_W'(1);
      drv_q    <= vec_drv;
      exp_q    <= vec_exp;
    end else if (at_last) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      slot_q <= slot_q + SLOT_W'(1);
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign idx_o    = cur_q;
  assign drv_o    = drv_q;
  assign exp_o    = exp_q;

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < SLOTS);  // R1
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && slot_q != LAST) |=> (active_q && slot_q == $past(slot_q) + SLOT_W'(1)));  // R1
  AST_TAKE_STARTS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (active_q && slot_q == '0));  // R2
  AST_STALL_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !vec_valid) |=> !active_q);  // R9
endmodule

// File: rtl/vwx_tptable.sv
module vwx_tptable #(
  parameter int PINS  = 8,
  parameter int SLOTS = 20,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int PIN_W  = (PINS > 1) ? $clog2(PINS) : 1,
  localparam int BITS   = PINS * SLOTS * 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              we_i,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [2:0]        code_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [PINS*3-1:0] rd_codes_o
);
  logic [BITS-1:0] mem_q;
  logic            wr_ok;

  assign wr_ok = we_i && !active_i && (int'(pin_i) < PINS) && (int'(slot_i) < SLOTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_ok) begin
      mem_q[(int'(pin_i) * SLOTS + int'(slot_i)) * 3 +: 3] <= code_i;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_rd
    assign rd_codes_o[p*3 +: 3] = mem_q[(p * SLOTS + int'(rd_slot_i)) * 3 +: 3];
  end

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> $stable(mem_q));  // R10
endmodule

// File: rtl/vwx_drive_lane.sv
module vwx_drive_lane
  import vwx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic [2:0] code_i,
  input  logic       data_i,
  output logic       lvl_o,
  output logic       oe_o
);
  logic hold_lvl_q, hold_oe_q;

  always_comb begin
    lvl_o = hold_lvl_q;
    oe_o  = hold_oe_q;
    if (active_i) begin
      case (code_i)
        TC_FORCE0: begin lvl_o = 1'b0;   oe_o = 1'b1; end
        TC_APPLY:  begin lvl_o = data_i; oe_o = 1'b1; end
        TC_HOLD:   begin lvl_o = hold_lvl_q; oe_o = hold_oe_q; end
        default:   begin lvl_o = 1'b0;   oe_o = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_lvl_q <= 1'b0;
      hold_oe_q  <= 1'b0;
    end else begin
      hold_lvl_q <= lvl_o;
      hold_oe_q  <= oe_o;
    end
  end

  AST_IDLE_KEEPS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (active_i || ($stable(lvl_o) && $stable(oe_o))));  // R9
  AST_FLOAT_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !lvl_o);  // R6
endmodule

// File: rtl/vwx_strobe.sv
module vwx_strobe
  import vwx_pkg::*;
#(
  parameter int N_CMP = 4,
  parameter int IDX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic [N_CMP*3-1:0] codes_i,
  input  logic [2*N_CMP-1:0] exp_i,
  input  logic [N_CMP-1:0]   pins_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               fail_o,
  output logic [IDX_W-1:0]   fail_idx_o
);
  logic [N_CMP-1:0] miss;

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    logic strobe;
    assign strobe  = active_i && (codes_i[c*3 +: 3] == TC_EXPECT);
    assign miss[c] = strobe &&
                     ((exp_i[2*c +: 2] == EXP_LOW  &&  pins_i[c]) ||
                      (exp_i[2*c +: 2] == EXP_HIGH && !pins_i[c]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_o     <= 1'b0;
      fail_idx_o <= '0;
    end else if (!fail_o && (|miss)) begin
      fail_o     <= 1'b1;
      fail_idx_o <= idx_i;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> fail_o);  // R8
  AST_FAIL_IDX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> $stable(fail_idx_o));  // R8
  AST_NO_COMPARE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !fail_o) |=> !fail_o);  // R9
endmodule

// File: rtl/vec_expander.sv
module vec_expander
  import vwx_pkg::*;
#(
  parameter int N_DRV = 4,
  parameter int N_CMP = 4,
  parameter int SLOTS = 20,
  parameter int IDX_W = 16,
  localparam int PINS   = N_DRV + N_CMP,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int PIN_W  = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [PIN_W-1:0]   tbl_pin,
  input  logic [SLOT_W-1:0]  tbl_slot,
  input  logic [2:0]         tbl_code,
  input  logic               vec_valid,
  output logic               vec_ready,
  input  logic [N_DRV-1:0]   vec_drv,
  input  logic [2*N_CMP-1:0] vec_exp,
  output logic [N_DRV-1:0]   drv_lvl,
  output logic [N_DRV-1:0]   drv_oe,
  input  logic [N_CMP-1:0]   cmp_in,
  output logic               fail,
  output logic [IDX_W-1:0]   fail_vec
);
  logic               active;
  logic [SLOT_W-1:0]  slot;
  logic [IDX_W-1:0]   idx;
  logic [N_DRV-1:0]   cur_drv;
  logic [2*N_CMP-1:0] cur_exp;
  logic [PINS*3-1:0]  codes;

  vwx_sequencer #(.SLOTS(SLOTS), .IDX_W(IDX_W), .N_DRV(N_DRV), .N_CMP(N_CMP)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_drv(vec_drv), .vec_exp(vec_exp),
    .active_o(active), .slot_o(slot), .idx_o(idx),
    .drv_o(cur_drv), .exp_o(cur_exp)
  );

  vwx_tptable #(.PINS(PINS), .SLOTS(SLOTS)) u_tab (
    .clk(clk), .rst_n(rst_n), .active_i(active),
    .we_i(tbl_we), .pin_i(tbl_pin), .slot_i(tbl_slot), .code_i(tbl_code),
    .rd_slot_i(slot), .rd_codes_o(codes)
  );

  for (genvar p = 0; p < N_DRV; p++) begin : g_lane
    vwx_drive_lane u_lane (
      .clk(clk), .rst_n(rst_n), .active_i(active),
      .code_i(codes[p*3 +: 3]), .data_i(cur_drv[p]),
      .lvl_o(drv_lvl[p]), .oe_o(drv_oe[p])
    );
  end

  vwx_strobe #(.N_CMP(N_CMP), .IDX_W(IDX_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active_i(active),
    .codes_i(codes[N_DRV*3 +: N_CMP*3]), .exp_i(cur_exp),
    .pins_i(cmp_in), .idx_i(idx),
    .fail_o(fail), .fail_idx_o(fail_vec)
  );

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> vec_ready);  // R2
endmodule

// File: tb/vec_expander_test.sv
module vec_expander_test;
  localparam int ND = 4;
  localparam int NC = 4;
  localparam int NS = 20;
  localparam int IW = 16;

  typedef struct packed {
    logic [ND-1:0] lvl;
    logic [ND-1:0] oe;
    logic [NC-1:0] resp;
    logic          mism;
    logic [IW-1:0] idx;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_pin = '0;
  logic [4:0] tbl_slot = '0;
  logic [2:0] tbl_code = '0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [ND-1:0] vec_drv = '0;
  logic [2*NC-1:0] vec_exp = '0;
  logic [ND-1:0] drv_lvl, drv_oe;
  logic [NC-1:0] cmp_in = '0;
  logic fail;
  logic [IW-1:0] fail_vec;

  int checks = 0;
  int fails = 0;
  int rem = 0;
  bit started = 1'b0;
  item_t q[$];
  logic [2:0] tab [ND+NC][NS];
  logic [ND-1:0] ml = '0, mo = '0;
  int vcount = 0;

  always #2 clk = ~clk;

  vec_expander #(.N_DRV(ND), .N_CMP(NC), .SLOTS(NS), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_pin(tbl_pin), .tbl_slot(tbl_slot),
    .tbl_code(tbl_code), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_drv(vec_drv), .vec_exp(vec_exp), .drv_lvl(drv_lvl), .drv_oe(drv_oe),
    .cmp_in(cmp_in), .fail(fail), .fail_vec(fail_vec)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // table write; upd says whether the write should land (R10)
  task automatic wr(input int p, input int s, input logic [2:0] c, input bit upd);
    tbl_we = 1'b1; tbl_pin = 3'(p); tbl_slot = 5'(s); tbl_code = c;
    @(negedge clk);
    tbl_we = 1'b0;
    if (upd) tab[p][s] = c;
  endtask

  // driver: pushes the expected per-slot items, then performs the handshake
  task automatic send_vec(input logic [ND-1:0] d, input logic [2*NC-1:0] e, input logic [NC-1:0] r);
    for (int s = 0; s < NS; s++) begin
      item_t it;
      for (int p = 0; p < ND; p++) begin
        case (tab[p][s])
          3'd0: begin it.lvl[p] = 1'b0; it.oe[p] = 1'b1; end
          3'd1: begin it.lvl[p] = d[p]; it.oe[p] = 1'b1; end
          3'd2: begin it.lvl[p] = ml[p]; it.oe[p] = mo[p]; end
          default: begin it.lvl[p] = 1'b0; it.oe[p] = 1'b0; end
        endcase
      end
      ml = it.lvl; mo = it.oe;
      it.mism = 1'b0;
      for (int c = 0; c < NC; c++) begin
        bit strobe;
        strobe = (tab[ND+c][s] == 3'd5);
        it.resp[c] = strobe ? r[c] : ~r[c];
        if (strobe && ((e[2*c +: 2] == 2'b01 && it.resp[c]) ||
                       (e[2*c +: 2] == 2'b10 && !it.resp[c]))) it.mism = 1'b1;
      end
      it.idx = IW'(vcount);
      q.push_back(it);
    end
    vcount++;
    vec_valid = 1'b1; vec_drv = d; vec_exp = e;
    while (!vec_ready) @(negedge clk);
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  // monitor: one step per cycle, just after the falling edge
  initial begin
    logic [ND-1:0] il = '0, io = '0;
    bit mfail = 1'b0;
    logic [IW-1:0] midx = '0;
    forever begin
      @(negedge clk); #1;
      if (started) begin
        chk(fail == mfail, "R7/R8 fail flag", 32'(fail), 32'(mfail));
        if (mfail) chk(fail_vec == midx, "R8 first failing vector", 32'(fail_vec), 32'(midx));
        chk(vec_ready == (rem <= 1), "R2 ready", 32'(vec_ready), 32'(rem <= 1));
        if (rem > 0) begin
          item_t it;
          it = q.pop_front();
          cmp_in = it.resp;
          chk(drv_lvl == it.lvl && drv_oe == it.oe, "R1/R3/R4/R5/R6/R10 drive",
              {drv_oe, drv_lvl}, {it.oe, it.lvl});
          il = it.lvl; io = it.oe;
          if (it.mism && !mfail) begin mfail = 1'b1; midx = it.idx; end
          rem--;
        end else begin
          chk(drv_lvl == il && drv_oe == io, "R9 idle hold", {drv_oe, drv_lvl}, {io, il});
        end
        if (vec_valid && vec_ready) rem += NS;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < ND + NC; p++)
      for (int s = 0; s < NS; s++) tab[p][s] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(vec_ready == 1'b1, "R11 ready after reset", 32'(vec_ready), 32'd1);
    chk(drv_oe == '0 && drv_lvl == '0, "R11 pins float", {drv_oe, drv_lvl}, 32'd0);
    chk(fail == 1'b0 && fail_vec == '0, "R11 fail clear", {fail, fail_vec}, 32'd0);
    started = 1'b1;
    @(negedge clk);
    // table load while idle
    for (int s = 0; s < NS; s++) begin
      wr(0, s, (s == 0) ? 3'd2 : 3'd1, 1'b1);
      wr(1, s, (s < 10) ? 3'd1 : 3'd0, 1'b1);
      wr(2, s, (s % 2 == 0) ? 3'd1 : ((s == 7) ? 3'd6 : 3'd3), 1'b1);
      wr(3, s, (s < 5) ? 3'd0 : 3'd2, 1'b1);
      for (int c = 0; c < 3; c++) wr(ND + c, s, (s == 11 || s == 12) ? 3'd5 : 3'd4, 1'b1);
      wr(ND + 3, s, (s == 0 || s == NS - 1) ? 3'd5 : 3'd0, 1'b1);
    end
    // back-to-back vectors, no mismatch
    send_vec(4'b1010, 8'b10_00_01_10, 4'b1101);
    send_vec(4'b0101, 8'b01_11_10_01, 4'b0010);
    send_vec(4'b1111, 8'b00_00_00_00, 4'b0110);
    send_vec(4'b0000, 8'b10_10_10_10, 4'b1111);
    // source stall (R9)
    while (rem > 0) @(negedge clk);
    repeat (8) @(negedge clk);
    send_vec(4'b1100, 8'b01_01_01_01, 4'b0000);
    // vector 5 fails on pin 5 (L sees 1), vector 6 fails again (R8 keeps 5)
    send_vec(4'b0011, 8'b10_10_01_10, 4'b1111);
    send_vec(4'b1001, 8'b01_00_00_00, 4'b1000);
    // write while playing is ignored (R10)
    wr(0, 5, 3'd3, 1'b0);
    send_vec(4'b1111, 8'b00_00_00_00, 4'b0000);
    while (rem > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    // write while idle lands (R10)
    wr(1, 0, 3'd3, 1'b1);
    send_vec(4'b1111, 8'b00_00_00_00, 4'b0000);
    while (rem > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(fail == 1'b1 && fail_vec == 16'd5, "R8 end state", {fail, fail_vec}, {1'b1, 16'd5});
    summary();
    $finish;
  end
endmodule